// File: doc/BRIEF.md
# Port Pin Interrupt Controller

This block turns a small group of port pins into a single maskable interrupt request for a CPU. Each pin has its own enable and its own polarity bit. The port as a whole is set to edge-only or edge-and-level sensitivity. Enabled pins are first adjusted for polarity and then ORed into one request line. The bus clock samples that line and checks it for an asserting edge. An edge sets a sticky flag, and software clears the flag by writing an acknowledge bit.

Raw pins pass through a two-flop synchronizer before the edge check. A second, combinational copy of the merged line works straight from the raw pins. While the stop input is high, that copy drives a wake output, so a wake request needs no running clock.

Software uses a small register interface with a write strobe, a write address and write data. The read data follows the read address combinationally. The block has no data stream, so every pin is a plain control or status signal and nothing applies back-pressure.

Top module: `port_pin_irq`

## Requirements
- R1: After reset, every register bit reads 0 and `irq_o` is low. Address 0 is control: bit 0 is acknowledge, bit 1 is interrupt enable, bit 2 is mode (1 = edge-and-level), bit 3 is the flag (read-only). Address 1 holds the pin enables, address 2 holds the polarity bits, and address 3 reads as 0.
- R2: A pin whose enable bit is 0 never sets the flag, whatever it does.
- R3: A polarity bit of 0 makes its pin active on a falling edge or low level. A polarity bit of 1 makes it active on a rising edge or high level.
- R4: An asserting edge is counted only if the synchronized merged line was deasserted in one cycle and asserted in the next. The flag reads 1 on the third rising clock edge after the pin changes, and not earlier.
- R5: Once set, the flag stays set until it is acknowledged, and it can be read at control bit 3.
- R6: `irq_o` is high exactly when both the flag and the interrupt enable are 1.
- R7: Writing 1 to control bit 0 clears the flag. That bit always reads 0. An edge seen in the same cycle as the acknowledge wins, and the flag stays set.
- R8: In edge-only mode, an edge on one enabled pin is lost while any other enabled pin is held at its asserted level.
- R9: In edge-and-level mode, an acknowledge has no effect while the merged line is asserted. Once the line deasserts, an acknowledge clears the flag.
- R10: A write to the enable or polarity register never sets the flag by itself. Edge detection is suppressed in the cycle after such a write.
- R11: While `stop_i` is high, `wake_o` equals the merged, polarity-adjusted level of the enabled raw pins, with no clock delay. While `stop_i` is low, `wake_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw port pin levels |
| stop_i | input | 1 | System stopped; selects the asynchronous wake path |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Register read data |
| irq_o | output | 1 | Interrupt request to the CPU |
| wake_o | output | 1 | Asynchronous wake request |

## Verification
Any fault in the previous-sample or suppression state shows as a flag edge that comes one cycle too early or too late, a flag that never appears, or a spurious one. Because the flag is read back and drives `irq_o`, the error reaches the ports on the same clock. A fault in the synchronizer shifts every flag set by a cycle, and the clock-by-clock comparison catches that on the first edge. Corrupted enable or polarity state changes `wake_o` as soon as a pin moves while stopped.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_EN   = 2'd1;
  localparam logic [1:0] ADDR_POL  = 2'd2;
  localparam int CTRL_ACK  = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_MODE = 2;
  localparam int CTRL_FLAG = 3;
  localparam int CTRL_BITS = 4;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/pin_merge.sv
module pin_merge #(
  parameter int N = 4
) (
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] pol_i,
  output logic         line_o
);
  logic [N-1:0] active;
  for (genvar i = 0; i < N; i++) begin : g_adj
    assign active[i] = en_i[i] & ~(lvl_i[i] ^ pol_i[i]);
  end
  assign line_o = |active;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import port_irq_pkg::*;
#(
  parameter int N      = 4,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N-1:0]      en_o,
  output logic [N-1:0]      pol_o,
  output logic              mode_o,
  output logic              ie_o,
  output logic              ack_o,
  output logic              cfg_wr_o
);
  logic wr_ctrl, wr_en_reg, wr_pol;

  assign wr_ctrl   = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_en_reg = wr_en_i && (wr_addr_i == ADDR_EN);
  assign wr_pol    = wr_en_i && (wr_addr_i == ADDR_POL);
  assign ack_o     = wr_ctrl && wr_data_i[CTRL_ACK];
  assign cfg_wr_o  = wr_en_reg || wr_pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o   <= '0;
      pol_o  <= '0;
      mode_o <= 1'b0;
      ie_o   <= 1'b0;
    end else begin
      if (wr_en_reg) en_o  <= wr_data_i[N-1:0];
      if (wr_pol)    pol_o <= wr_data_i[N-1:0];
      if (wr_ctrl) begin
        ie_o   <= wr_data_i[CTRL_IE];
        mode_o <= wr_data_i[CTRL_MODE];
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADDR_CTRL: begin
        rd_data_o[CTRL_IE]   = ie_o;
        rd_data_o[CTRL_MODE] = mode_o;
        rd_data_o[CTRL_FLAG] = flag_i;
      end
      ADDR_EN:  rd_data_o[N-1:0] = en_o;
      ADDR_POL: rd_data_o[N-1:0] = pol_o;
      default:  rd_data_o = '0;
    endcase
  end

  assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_reg |=> (en_o == $past(wr_data_i[N-1:0])));
  assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == ADDR_CTRL) |-> !rd_data_o[CTRL_ACK]);
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic mode_i,
  input  logic ack_i,
  input  logic cfg_wr_i,
  output logic flag_o
);
  logic prev_q, hold_q, edge_hit, clr;

  assign edge_hit = line_i && !prev_q && !hold_q;
  assign clr      = ack_i && !(mode_i && line_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hold_q <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      prev_q <= line_i;
      hold_q <= cfg_wr_i;
      if (edge_hit)  flag_o <= 1'b1;
      else if (clr)  flag_o <= 1'b0;
    end
  end

  assert_edge_sets_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (line_i && !prev_q && !hold_q) |=> flag_o);
  assert_level_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && mode_i && line_i) |=> flag_o);
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !flag_o) |=> !flag_o);
  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !ack_i) |=> flag_o);
endmodule

// File: rtl/port_pin_irq.sv
module port_pin_irq
  import port_irq_pkg::*;
#(
  parameter int NPINS  = 4,
  localparam int DATA_W = (NPINS > CTRL_BITS) ? NPINS : CTRL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              stop_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] pin_s, en, pol;
  logic mode, ie, ack, cfg_wr, flag, line_sync, line_async;

  pin_sync #(.N(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  pin_merge #(.N(NPINS)) u_merge_sync (
    .lvl_i(pin_s), .en_i(en), .pol_i(pol), .line_o(line_sync)
  );

  pin_merge #(.N(NPINS)) u_merge_async (
    .lvl_i(pin_i), .en_i(en), .pol_i(pol), .line_o(line_async)
  );

  irq_regs #(.N(NPINS), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .flag_i(flag),
    .rd_data_o(rd_data_o), .en_o(en), .pol_o(pol), .mode_o(mode),
    .ie_o(ie), .ack_o(ack), .cfg_wr_o(cfg_wr)
  );

  irq_flag_unit u_flag (
    .clk(clk), .rst_n(rst_n), .line_i(line_sync), .mode_i(mode),
    .ack_i(ack), .cfg_wr_i(cfg_wr), .flag_o(flag)
  );

  assign irq_o  = flag && ie;
  assign wake_o = stop_i && line_async;

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag && ie));
endmodule

// File: tb/port_pin_irq_test.sv
module port_pin_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_i = '1;
  logic stop_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [N-1:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [N-1:0] rd_data_o;
  logic irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;

  port_pin_irq #(.NPINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .stop_i(stop_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
    .wake_o(wake_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  bit [N-1:0] m_s1, m_s2, m_en, m_pol;
  bit m_mode, m_ie, m_flag, m_prev, m_hold;

  function automatic bit asserted_any(bit [N-1:0] lv);
    for (int i = 0; i < N; i++)
      if (m_en[i] && (lv[i] == m_pol[i])) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_en = '0; m_pol = '0;
      m_mode = 0; m_ie = 0; m_flag = 0; m_prev = 0; m_hold = 0;
    end else begin
      bit lvl, hit, ackw;
      lvl  = asserted_any(m_s2);
      hit  = lvl && !m_prev && !m_hold;
      ackw = wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[0];
      if (hit) m_flag = 1;
      else if (ackw && !(m_mode && lvl)) m_flag = 0;
      m_prev = lvl;
      m_hold = wr_en_i && (wr_addr_i == 2'd1 || wr_addr_i == 2'd2);
      m_s2 = m_s1;
      m_s1 = pin_i;
      if (wr_en_i) begin
        case (wr_addr_i)
          2'd0: begin m_ie = wr_data_i[1]; m_mode = wr_data_i[2]; end
          2'd1: m_en = wr_data_i;
          2'd2: m_pol = wr_data_i;
          default: ;
        endcase
      end
    end
    #(CLK_PERIOD/4);
    begin
      int exp_rd;
      case (rd_addr_i)
        2'd0: exp_rd = (int'(m_flag) << 3) | (int'(m_mode) << 2) | (int'(m_ie) << 1);
        2'd1: exp_rd = int'(m_en);
        2'd2: exp_rd = int'(m_pol);
        default: exp_rd = 0;
      endcase
      chk("R5 readback", int'(rd_data_o), exp_rd);
      chk("R6 irq", int'(irq_o), int'(m_flag && m_ie));
      chk("R11 wake", int'(wake_o), int'(stop_i && asserted_any(pin_i)));
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [N-1:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic flag_is(string tag, int exp);
    chk(tag, int'(rd_data_o[3]), exp);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1 reset ctrl", int'(rd_data_o), 0);
    chk("R1 reset irq", int'(irq_o), 0);
    rst_n = 1'b1;
    cyc(2);
    rd_addr_i = 2'd1; #1; chk("R1 reset enables", int'(rd_data_o), 0);
    rd_addr_i = 2'd3; #1; chk("R1 addr3 zero", int'(rd_data_o), 0);
    rd_addr_i = 2'd0;

    // R3 falling edge on pin 0, R4 latency
    wr(2'd1, 4'b0001);
    wr(2'd0, 4'b0010);
    cyc(3);
    pin_i[0] = 1'b0;
    cyc(2); flag_is("R4 not yet", 0);
    cyc(1); flag_is("R4 set", 1);
    chk("R6 irq high", int'(irq_o), 1);
    cyc(2); flag_is("R5 sticky", 1);
    pin_i = '1; cyc(3);
    wr(2'd0, 4'b0011);
    flag_is("R7 ack clears", 0);
    chk("R7 ack reads 0", int'(rd_data_o[0]), 0);

    // R2 disabled pin
    pin_i[1] = 1'b0; cyc(4); flag_is("R2 disabled pin", 0);
    pin_i = '1; cyc(3);

    // R3 rising polarity; pin 0 already high, R10 for polarity write
    wr(2'd2, 4'b0001);
    cyc(3); flag_is("R10 pol write", 0);
    pin_i[0] = 1'b0; cyc(4); flag_is("R3 rising armed", 0);
    pin_i[0] = 1'b1; cyc(4); flag_is("R3 rising", 1);
    wr(2'd0, 4'b0011); flag_is("R7 ack", 0);
    wr(2'd2, 4'b0000); cyc(3);

    // R10 enable write while pin held asserted
    wr(2'd1, 4'b0000);
    pin_i[0] = 1'b0; cyc(3);
    wr(2'd1, 4'b0001);
    cyc(4); flag_is("R10 enable write", 0);
    pin_i = '1; cyc(3);

    // R8 merge loss
    wr(2'd1, 4'b0011); cyc(2);
    pin_i[1] = 1'b0; cyc(4); flag_is("R8 pin1 edge", 1);
    wr(2'd0, 4'b0011); flag_is("R7 ack edge mode", 0);
    pin_i[0] = 1'b0; cyc(4); flag_is("R8 lost edge", 0);
    pin_i = '1; cyc(3);

    // R9 level mode
    wr(2'd0, 4'b0110);
    pin_i[0] = 1'b0; cyc(4); flag_is("R9 set", 1);
    wr(2'd0, 4'b0111); cyc(1); flag_is("R9 ack blocked", 1);
    pin_i = '1; cyc(4);
    wr(2'd0, 4'b0111); flag_is("R9 ack after release", 0);

    // R7 edge wins over acknowledge in the same cycle
    wr(2'd0, 4'b0010);
    pin_i[0] = 1'b0; cyc(2);
    wr(2'd0, 4'b0011); flag_is("R7 edge wins", 1);
    pin_i = '1; cyc(3); wr(2'd0, 4'b0011);

    // R11 asynchronous wake
    stop_i = 1'b1;
    #1; chk("R11 idle", int'(wake_o), 0);
    pin_i[0] = 1'b0; #1; chk("R11 wake pin0", int'(wake_o), 1);
    pin_i[0] = 1'b1; pin_i[3] = 1'b0; #1; chk("R11 disabled pin", int'(wake_o), 0);
    pin_i = '1;
    cyc(2);
    stop_i = 1'b0;
    pin_i[1] = 1'b0; #1; chk("R11 not stopped", int'(wake_o), 0);
    pin_i = '1;
    cyc(4);
    finish_run();
  end
endmodule